// File: doc/BRIEF.md
# Adaptive Midpoint Sync Slicer

The block turns a stream of unsigned video samples, in which the sync tip is the lowest level, into a clean composite-sync bit. A fixed coarse threshold, a set offset above the clamp level, finds the edges of each sync pulse. Two timed windows then measure the signal. The first window opens a programmable delay after the falling sync edge and reads the tip level. The second window opens after the rising sync edge and reads the back-porch level. Each window's average feeds a first-order per-line filter that holds a level, so the held levels settle within a few lines.

The slice level is the midpoint of the two held levels. A comparator with programmable hysteresis applies that slice level to every sample. Its decision leaves the block two valid samples later as an active-low sync output. The block also drives an active-low back-porch pulse of fixed width, which restarts on every rising sync edge, serration pulses included. When video disappears no edges occur, so the held levels freeze and a tip-level input keeps the sync output low.

Every register advances only on samples marked valid. All window positions are counted in valid samples from the edge sample, and the edge sample is index 0.

Top module: `sync_slicer`

## Requirements
- R1: A sample is coarse-low when it is below CLAMP_LVL+COARSE_OFS. A leading edge is the first coarse-low sample after a sample that is not coarse-low, and a trailing edge is the first sample that is not coarse-low after a coarse-low one. A pulse that never goes below this level starts no window, changes no level and starts no back-porch pulse.
- R2: The tip window averages the samples at indices TIP_DLY to TIP_DLY+2^TIP_LG-1 after a leading edge (a plain mean). It then updates the tip level.
- R3: A trailing edge that arrives before the tip window has taken its last sample cancels that window, and the tip level is left unchanged for that line.
- R4: The porch window averages the samples at indices BP_DLY to BP_DLY+2^BP_LG-1 after a trailing edge, then updates the porch level. A leading edge that arrives before the window completes cancels it, and the porch level is left unchanged.
- R5: A level update computes new = old + floor((avg - old) / 2^IIR_SH). Both levels reset to 2^(DW-1).
- R6: slice_lvl equals floor((tip_lvl + porch_lvl) / 2) at all times.
- R7: The internal sync decision is hysteretic. While it is set, it stays set for a sample at or below slice+HYST. While it is clear, it becomes set only for a sample below slice-HYST.
- R8: csync_n is the inverse of the decision made on the valid sample two valid samples earlier, so a low output means sync.
- R9: bp_flag_n goes low at the clock edge that takes a trailing-edge sample. It stays low for exactly BP_W valid samples, and every new trailing edge restarts this count.
- R10: Without coarse edges the held levels stay constant. A continuous tip-level input keeps csync_n low for as long as it lasts.
- R11: A cycle with smp_vld low changes no output and no held level.
- R12: After reset, csync_n and bp_flag_n are high and all three levels read 2^(DW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample word is valid this cycle |
| smp_data | input | DW | Unsigned video sample, sync tip lowest |
| csync_n | output | 1 | Composite sync, active low, two-sample latency |
| bp_flag_n | output | 1 | Back-porch pulse, active low, BP_W samples |
| tip_lvl | output | DW | Held sync-tip level |
| porch_lvl | output | DW | Held back-porch level |
| slice_lvl | output | DW | Midpoint slice level |

## Verification
The tip window's last sample and the trailing edge that ends it can land one sample apart, so the bench sends sync widths one short of the window end and exactly at it. Only the wider pulse may move the tip level. The same trailing edge also starts the porch window and the back-porch pulse, so both effects are judged on a single line. Serration trains and short porches put a leading edge inside a running porch window. The bench expects that window to be discarded while the back-porch pulse is still restarted on each rising edge.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef struct packed {
        logic lead;
        logic trail;
    } ss_edge_t;
endpackage

// File: rtl/ss_edge_det.sv
module ss_edge_det
    import ss_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CLAMP = 16,
    parameter int OFS   = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [DW-1:0] smp,
    output ss_edge_t      edg
);
    localparam logic [DW:0] CTHR = (DW+1)'(CLAMP + OFS);

    logic below;
    logic coarse_d, coarse_q;

    always_comb begin
        below     = ({1'b0, smp} < CTHR);
        edg.lead  = vld & below & ~coarse_q;
        edg.trail = vld & ~below & coarse_q;
        coarse_d  = vld ? below : coarse_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coarse_q <= 1'b0;
        else        coarse_q <= coarse_d;
    end
endmodule

// File: rtl/ss_gate_avg.sv
module ss_gate_avg #(
    parameter int DW  = 8,
    parameter int DLY = 2,
    parameter int LG  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [DW-1:0] smp,
    input  logic          start,
    input  logic          abort,
    output logic          done,
    output logic [DW-1:0] avg
);
    localparam int LEN  = 1 << LG;
    localparam int LAST = DLY + LEN - 1;
    localparam int CW   = $clog2(LAST + 2);
    localparam int AW   = DW + LG;

    typedef struct packed {
        logic [CW-1:0] pos;
        logic [AW-1:0] acc;
    } gate_t;

    gate_t         st_d, st_q;
    logic [AW-1:0] sum;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        sum  = st_q.acc + AW'(smp);
        avg  = sum[AW-1:LG];
        if (vld) begin
            if (start) begin
                st_d.pos = CW'(1);
                st_d.acc = '0;
            end else if (st_q.pos != '0) begin
                if (abort) begin
                    st_d.pos = '0;
                end else if (st_q.pos >= CW'(DLY)) begin
                    st_d.acc = sum;
                    if (st_q.pos == CW'(LAST)) begin
                        done     = 1'b1;
                        st_d.pos = '0;
                    end else begin
                        st_d.pos = st_q.pos + CW'(1);
                    end
                end else begin
                    st_d.pos = st_q.pos + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ss_level_iir.sv
module ss_level_iir #(
    parameter int DW = 8,
    parameter int SH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] avg,
    output logic [DW-1:0] lvl
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic [DW-1:0]      lvl_d, lvl_q;
    logic signed [DW+1:0] diff, stp;

    always_comb begin
        diff  = $signed({2'b00, avg}) - $signed({2'b00, lvl_q});
        stp   = diff >>> SH;
        lvl_d = upd ? DW'($signed({2'b00, lvl_q}) + stp) : lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= MID;
        else        lvl_q <= lvl_d;
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/sync_slicer.sv
module sync_slicer
    import ss_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CLAMP_LVL  = 16,
    parameter int COARSE_OFS = 24,
    parameter int TIP_DLY    = 22,
    parameter int TIP_LG     = 5,
    parameter int BP_DLY     = 6,
    parameter int BP_LG      = 5,
    parameter int BP_W       = 95,
    parameter int HYST       = 4,
    parameter int IIR_SH     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    output logic          csync_n,
    output logic          bp_flag_n,
    output logic [DW-1:0] tip_lvl,
    output logic [DW-1:0] porch_lvl,
    output logic [DW-1:0] slice_lvl
);
    localparam int          BW = $clog2(BP_W + 1);
    localparam logic [DW:0] HV = (DW+1)'(HYST);

    ss_edge_t      edg;
    logic [1:0]    g_start, g_abort, g_done;
    logic [DW-1:0] g_avg [2];
    logic [DW-1:0] g_lvl [2];

    ss_edge_det #(.DW(DW), .CLAMP(CLAMP_LVL), .OFS(COARSE_OFS)) u_edge (
        .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp(smp_data), .edg(edg)
    );

    // Index 0 measures the tip, index 1 the back porch.
    for (genvar gi = 0; gi < 2; gi++) begin : g_meas
        localparam int G_DLY = (gi == 0) ? TIP_DLY : BP_DLY;
        localparam int G_LG  = (gi == 0) ? TIP_LG  : BP_LG;

        assign g_start[gi] = (gi == 0) ? edg.lead  : edg.trail;
        assign g_abort[gi] = (gi == 0) ? edg.trail : edg.lead;

        ss_gate_avg #(.DW(DW), .DLY(G_DLY), .LG(G_LG)) u_gate (
            .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp(smp_data),
            .start(g_start[gi]), .abort(g_abort[gi]),
            .done(g_done[gi]), .avg(g_avg[gi])
        );

        ss_level_iir #(.DW(DW), .SH(IIR_SH)) u_iir (
            .clk(clk), .rst_n(rst_n), .upd(g_done[gi]),
            .avg(g_avg[gi]), .lvl(g_lvl[gi])
        );
    end

    typedef struct packed {
        logic [BW-1:0] bcnt;
        logic          s1;
        logic          s2;
    } top_t;

    top_t          t_d, t_q;
    logic [DW-1:0] thr;
    logic          enter, stay;

    always_comb begin
        t_d   = t_q;
        thr   = DW'(({1'b0, g_lvl[0]} + {1'b0, g_lvl[1]}) >> 1);
        enter = ({1'b0, smp_data} + HV) < {1'b0, thr};
        stay  = {1'b0, smp_data} <= ({1'b0, thr} + HV);
        if (smp_vld) begin
            t_d.s1 = t_q.s1 ? stay : enter;
            t_d.s2 = t_q.s1;
            if (edg.trail)             t_d.bcnt = BW'(BP_W);
            else if (t_q.bcnt != '0)   t_d.bcnt = t_q.bcnt - BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign csync_n   = ~t_q.s2;
    assign bp_flag_n = (t_q.bcnt == '0);
    assign tip_lvl   = g_lvl[0];
    assign porch_lvl = g_lvl[1];
    assign slice_lvl = thr;
endmodule

// File: rtl/ss_slicer_chk.sv
module ss_slicer_chk #(
    parameter int DW   = 8,
    parameter int HYST = 4,
    parameter int BP_W = 95
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic [DW-1:0] smp_data,
    input logic          trail,
    input logic          tip_done,
    input logic          bp_done,
    input logic          csync_n,
    input logic          bp_flag_n,
    input logic [DW-1:0] tip_lvl,
    input logic [DW-1:0] porch_lvl,
    input logic [DW-1:0] slice_lvl
);
    localparam int          SW = $clog2(BP_W + 1);
    localparam logic [DW:0] HV = (DW+1)'(HYST);

    logic [SW-1:0] since_q;
    logic          armed_q;
    logic          lo_smp, hi_smp;

    assign lo_smp = ({1'b0, smp_data} + HV) < {1'b0, slice_lvl};
    assign hi_smp = {1'b0, smp_data} > ({1'b0, slice_lvl} + HV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= SW'(BP_W);
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (smp_vld && trail)                 since_q <= '0;
            else if (smp_vld && since_q < SW'(BP_W)) since_q <= since_q + SW'(1);
        end
    end

    assert_flag_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && trail |=> !bp_flag_n);

    assert_flag_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        since_q >= SW'(BP_W) |-> bp_flag_n);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(csync_n) && $stable(bp_flag_n)
                     && $stable(tip_lvl) && $stable(porch_lvl));

    assert_tip_only_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tip_done |=> $stable(tip_lvl));

    assert_porch_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_done |=> $stable(porch_lvl));

    assert_enter_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && smp_vld && $past(smp_vld && lo_smp) |=> !csync_n);

    assert_leave_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && smp_vld && $past(smp_vld && hi_smp) |=> csync_n);
endmodule

bind sync_slicer ss_slicer_chk #(.DW(DW), .HYST(HYST), .BP_W(BP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .trail(edg.trail), .tip_done(g_done[0]), .bp_done(g_done[1]),
    .csync_n(csync_n), .bp_flag_n(bp_flag_n), .tip_lvl(tip_lvl),
    .porch_lvl(porch_lvl), .slice_lvl(slice_lvl)
);

// File: tb/sync_slicer_bench.sv
module sync_slicer_bench;
    localparam int DW = 8, CL = 16, OFS = 24, TD = 2, TLG = 2, BD = 2, BLG = 2;
    localparam int BPW = 8, HY = 4, SH = 2;
    localparam int TIP_NEED = TD + (1 << TLG);
    localparam int BP_NEED  = BD + (1 << BLG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          csync_n, bp_flag_n;
    logic [DW-1:0] tip_lvl, porch_lvl, slice_lvl;

    sync_slicer #(
        .DW(DW), .CLAMP_LVL(CL), .COARSE_OFS(OFS), .TIP_DLY(TD), .TIP_LG(TLG),
        .BP_DLY(BD), .BP_LG(BLG), .BP_W(BPW), .HYST(HY), .IIR_SH(SH)
    ) u_sync_slicer (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .csync_n(csync_n), .bp_flag_n(bp_flag_n), .tip_lvl(tip_lvl),
        .porch_lvl(porch_lvl), .slice_lvl(slice_lvl)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_tip = 128, m_por = 128;
    bit s1 = 0, s2 = 0, chk_cs = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iir(int l, int a);
        int d = a - l;
        int q = (d >= 0) ? d / (1 << SH) : -((-d + (1 << SH) - 1) / (1 << SH));
        return l + q;
    endfunction

    task automatic step(int v);
        int thr = (m_tip + m_por) / 2;
        smp_data = DW'(v);
        smp_vld  = 1'b1;
        @(posedge clk);
        #1;
        s2 = s1;
        s1 = s1 ? (v <= thr + HY) : (v < thr - HY);
        if (chk_cs) check(csync_n == !s2, "R7/R8 csync", int'(csync_n), int'(!s2));
    endtask

    task automatic idle();
        logic c = csync_n, b = bp_flag_n;
        logic [DW-1:0] t = tip_lvl, p = porch_lvl;
        smp_vld  = 1'b0;
        smp_data = '0;
        @(posedge clk);
        #1;
        check(csync_n == c && bp_flag_n == b, "R11 outputs", {csync_n, bp_flag_n}, {c, b});
        check(tip_lvl == t && porch_lvl == p, "R11 levels", int'(tip_lvl), int'(t));
    endtask

    task automatic line(int w, int tv, int p, int pv, int v, int vv, string tag);
        for (int i = 0; i < w; i++) step(tv);
        for (int j = 0; j < p + v; j++) begin
            step(j < p ? pv : vv);
            if (j == 0 || j == BPW - 1) check(bp_flag_n == 1'b0, "R9 flag low", int'(bp_flag_n), 0);
            if (j == BPW) check(bp_flag_n == 1'b1, "R9 flag end", int'(bp_flag_n), 1);
        end
        if (w >= TIP_NEED) m_tip = iir(m_tip, tv);
        if (p >= BP_NEED)  m_por = iir(m_por, pv);
        check(int'(tip_lvl) == m_tip, {tag, " R2/R5 tip"}, int'(tip_lvl), m_tip);
        check(int'(porch_lvl) == m_por, {tag, " R4/R5 porch"}, int'(porch_lvl), m_por);
        check(int'(slice_lvl) == (m_tip + m_por) / 2, {tag, " R6 slice"},
              int'(slice_lvl), (m_tip + m_por) / 2);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R12: state out of reset
        check(csync_n == 1'b1 && bp_flag_n == 1'b1, "R12 outputs", {csync_n, bp_flag_n}, 3);
        check(tip_lvl == 8'd128 && porch_lvl == 8'd128, "R12 levels", int'(tip_lvl), 128);
        check(slice_lvl == 8'd128, "R12 slice", int'(slice_lvl), 128);

        // Settling from mid-scale
        for (int k = 0; k < 20; k++) line(10, 20, 8, 100, 30, 180, "settle");
        chk_cs = 1;
        line(10, 20, 8, 100, 30, 180, "steady");

        // R3: sync one sample short of the tip window end, then exactly enough
        line(TIP_NEED - 1, 30, 8, 100, 30, 180, "R3 short");
        line(TIP_NEED, 30, 8, 100, 30, 180, "R3 full");

        // R4: leading edge inside the porch window
        line(10, 20, BP_NEED - 1, 140, 0, 0, "R4 cut");
        line(10, 20, 8, 100, 30, 180, "R4 after");

        // R9: serration train, flag restarts on each rising edge
        for (int k = 0; k < 6; k++) line(10, 20, 3, 100, 0, 0, "R9 serr");
        line(10, 20, 8, 100, 30, 180, "R9 end");

        // R1: level 40 is not coarse-low, 39 is
        for (int i = 0; i < 10; i++) step(CL + OFS);
        for (int i = 0; i < 8; i++) step(100);
        check(bp_flag_n == 1'b1, "R1 no edge flag", int'(bp_flag_n), 1);
        check(int'(tip_lvl) == m_tip && int'(porch_lvl) == m_por, "R1 no edge levels",
              int'(tip_lvl), m_tip);
        for (int i = 0; i < 30; i++) step(180);
        line(10, CL + OFS - 1, 8, 100, 30, 180, "R1 edge");
        for (int k = 0; k < 6; k++) line(10, 20, 8, 100, 30, 180, "restore");

        // R10: long tip-level input, held levels and low csync
        for (int i = 0; i < 300; i++) step(20);
        m_tip = iir(m_tip, 20);
        check(csync_n == 1'b0, "R10 csync held low", int'(csync_n), 0);
        check(int'(tip_lvl) == m_tip && int'(porch_lvl) == m_por, "R10 levels held",
              int'(porch_lvl), m_por);
        line(0, 20, 8, 100, 30, 180, "R10 end");

        // R7/R8/R11: exhaustive sweep from both decision states, idle cycles between
        for (int v = CL + OFS; v < 256; v++) begin
            step(200); step(v); step(200);
            step(45);  step(v); step(200);
            idle();
        end
        summary();
    end
endmodule